// File: doc/BRIEF.md
# Packet Trace Flight Recorder

This block runs beside a packet router and keeps an always-on history of router traffic. Each router port has a tap that pulses when a head flit or a tail flit crosses it. The recorder turns each tap event into a 35-bit record holding a trace identifier, the transaction size, the source and destination port codes, a head/tail marker and the queue-occupancy flags sampled at that moment. Records go into an on-chip circular store that keeps the 512 most recent events and overwrites the oldest when it is full.

Taps cannot be stalled, because the router never waits on its trace logic. Each tap therefore feeds a one-entry pending slot. A fixed-priority drain writes one slot per cycle, lowest port first, and a saturating counter reports every event that arrives while its port's slot is still occupied. A host reads the history at any time over a valid/ready stream. A start pulse freezes the extent of the log and the stream then runs from the oldest record to the newest. The sink may hold `rd_ready` low for any number of cycles; `rd_valid`, `rd_data` and `rd_last` then hold. Capture keeps running during a readout. If the store has already wrapped, a readout that overlaps fresh captures may return overwritten entries, so readouts of a wrapped log are meant for quiet periods.

A set of power-up milestone inputs, such as link lock, clock lock and reset release, is latched into sticky flags. The flags stay set until the host pulses a clear.

Top module: `pkt_trace_rec`

## Requirements
- R1: After reset, `rd_valid` and `rd_last` are 0, `drop_count` is 0, `ms_flags` is 0 and the log is empty.
- R2: A record has this bit layout: [34:19] trace id, [18:11] size, [10:8] source port code (equal to the tap index: 0-3 network ports, 4 host, 5 application), [7:5] destination code from the tap, [4] tail marker (1 = tail flit, 0 = head flit), [3:0] `q_nonempty` as sampled with the event.
- R3: Events from several taps in one cycle are stored on consecutive cycles in ascending tap index. A tap whose slot is being drained in a given cycle may load a new event in that same cycle, and the new event is again served before higher tap indices.
- R4: An event on a tap whose slot is still waiting and is not drained in that cycle is discarded, and `drop_count` rises by one per discarded event, saturating at all ones.
- R5: Only the 512 most recent records are kept. Once more than 512 events have been written, a readout returns exactly the latest 512.
- R6: A `rd_start` pulse while idle freezes the log extent, including any record written in that same cycle. The stream then returns every stored record from oldest to newest, with `rd_last` high on the newest only. An empty log produces no beats.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_valid`, `rd_data` and `rd_last` hold. A `rd_start` pulse during a readout is ignored.
- R8: Events keep being captured during a readout. Records written after the freeze are absent from that readout and present in the next one.
- R9: A high level on `ms_in[i]` in any cycle sets `ms_flags[i]` from the next cycle on. The flag stays set while `ms_clr` is low.
- R10: A `ms_clr` pulse replaces `ms_flags` with the `ms_in` value of that cycle, so the flags clear unless a milestone input is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tap_valid | input | NPORTS | Per-tap event strobe, one cycle per flit |
| tap_dst | input | 3*NPORTS | Per-tap destination port code |
| tap_tail | input | NPORTS | Per-tap marker: 1 tail flit, 0 head flit |
| tap_tid | input | 16*NPORTS | Per-tap trace identifier |
| tap_len | input | 8*NPORTS | Per-tap transaction size |
| q_nonempty | input | 4 | Router queue-occupancy flags stored with each event |
| rd_start | input | 1 | Pulse to freeze the log and begin a readout |
| rd_valid | output | 1 | Readout beat available |
| rd_ready | input | 1 | Readout sink accepts the beat |
| rd_data | output | 35 | Readout record |
| rd_last | output | 1 | Marks the newest record of the readout |
| drop_count | output | DROP_W | Saturating count of discarded events |
| ms_in | input | MS_W | Milestone level inputs |
| ms_clr | input | 1 | Pulse to clear the milestone flags |
| ms_flags | output | MS_W | Sticky milestone flags |

## Verification
Random bursts on random subsets of taps, each followed by enough idle cycles to drain, check the record layout and the ascending write order. A wrong priority or a swapped field shows up as a mismatch against the bench model. A directed back-to-back burst, in which a drained tap refills while an undrained tap fires again, separates the refill path from the drop path and checks the counter. A long stream of single events pushes the log past 512 entries to check wraparound, and readouts run under random back-pressure, with an event injected and a stray start pulse mid-stream, to check hold behaviour and the freeze point. The milestone inputs are pulsed and cleared, once with an input still high, to tell sticky flags apart from level-following ones.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  localparam int TID_W  = 16;
  localparam int LEN_W  = 8;
  localparam int PORT_W = 3;
  localparam int STAT_W = 4;

  typedef struct packed {
    logic [TID_W-1:0]  tid;
    logic [LEN_W-1:0]  len;
    logic [PORT_W-1:0] src;
    logic [PORT_W-1:0] dst;
    logic              tail;
    logic [STAT_W-1:0] stat;
  } trace_rec_t;

  localparam int REC_W = $bits(trace_rec_t);
endpackage

// File: rtl/ptr_ingest.sv
module ptr_ingest
  import ptr_pkg::*;
#(
  parameter int NPORTS = 6,
  parameter int DROP_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORTS-1:0]         tap_valid,
  input  logic [NPORTS*PORT_W-1:0]  tap_dst,
  input  logic [NPORTS-1:0]         tap_tail,
  input  logic [NPORTS*TID_W-1:0]   tap_tid,
  input  logic [NPORTS*LEN_W-1:0]   tap_len,
  input  logic [STAT_W-1:0]         q_stat,
  output logic                      wr_en,
  output trace_rec_t                wr_rec,
  output logic [NPORTS-1:0]         grant,
  output logic [DROP_W-1:0]         drop_count
);
  localparam int NCNT_W = $clog2(NPORTS + 1);

  trace_rec_t          tap_rec [NPORTS];
  trace_rec_t          slot_q  [NPORTS];
  logic [NPORTS-1:0]   slot_v;
  logic [NPORTS-1:0]   take;
  logic [NPORTS-1:0]   drop;
  logic [NCNT_W-1:0]   n_drop;
  logic [DROP_W:0]     drop_sum;

  // Pack each tap's fields into a record; the source code is the tap index.
  for (genvar p = 0; p < NPORTS; p++) begin : g_tap
    assign tap_rec[p] = '{tid:  tap_tid[p*TID_W +: TID_W],
                          len:  tap_len[p*LEN_W +: LEN_W],
                          src:  PORT_W'(p),
                          dst:  tap_dst[p*PORT_W +: PORT_W],
                          tail: tap_tail[p],
                          stat: q_stat};
  end

  // Fixed priority: the lowest waiting slot drains each cycle.
  assign grant = slot_v & (~slot_v + NPORTS'(1));
  assign take  = tap_valid & (~slot_v | grant);
  assign drop  = tap_valid & slot_v & ~grant;

  always_ff @(posedge clk) begin
    if (!rst_n) slot_v <= '0;
    else        slot_v <= (slot_v & ~grant) | take;
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORTS; p++) begin
      if (take[p]) slot_q[p] <= tap_rec[p];
    end
  end

  always_comb begin
    wr_rec = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (grant[p]) wr_rec = slot_q[p];
    end
  end

  assign wr_en = |slot_v;

  // Saturating count of discarded events.
  assign n_drop   = NCNT_W'($countones(drop));
  assign drop_sum = {1'b0, drop_count} + (DROP_W+1)'(n_drop);

  always_ff @(posedge clk) begin
    if (!rst_n)               drop_count <= '0;
    else if (drop_sum[DROP_W]) drop_count <= '1;
    else                      drop_count <= drop_sum[DROP_W-1:0];
  end
endmodule

// File: rtl/ptr_ring.sv
module ptr_ring
  import ptr_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  trace_rec_t wr_rec,
  input  logic       rd_start,
  input  logic       rd_ready,
  output logic       rd_valid,
  output trace_rec_t rd_rec,
  output logic       rd_last
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  trace_rec_t    mem [DEPTH];
  logic [AW-1:0] wp, wp_nxt, rp;
  logic          wrapped, wrap_nxt;
  logic          busy;
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_rec;
  end

  // Write pointer and wrap flag as they stand after this cycle's write.
  always_comb begin
    wp_nxt   = wp;
    wrap_nxt = wrapped;
    if (wr_en) begin
      if (wp == LAST_IDX) begin
        wp_nxt   = '0;
        wrap_nxt = 1'b1;
      end else begin
        wp_nxt = wp + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      wrapped <= 1'b0;
    end else begin
      wp      <= wp_nxt;
      wrapped <= wrap_nxt;
    end
  end

  // Readout: freeze extent on start, then stream oldest to newest.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      rp     <= '0;
      remain <= '0;
    end else if (!busy) begin
      if (rd_start && (wrap_nxt || wp_nxt != '0)) begin
        busy   <= 1'b1;
        rp     <= wrap_nxt ? wp_nxt : '0;
        remain <= wrap_nxt ? CW'(DEPTH) : CW'(wp_nxt);
      end
    end else if (rd_ready) begin
      rp     <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
      remain <= remain - 1'b1;
      if (remain == CW'(1)) busy <= 1'b0;
    end
  end

  assign rd_valid = busy;
  assign rd_rec   = mem[rp];
  assign rd_last  = busy && (remain == CW'(1));
endmodule

// File: rtl/ptr_milestone.sv
module ptr_milestone #(
  parameter int MS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MS_W-1:0] ms_in,
  input  logic            ms_clr,
  output logic [MS_W-1:0] ms_flags
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ms_flags <= '0;
    else if (ms_clr) ms_flags <= ms_in;
    else             ms_flags <= ms_flags | ms_in;
  end
endmodule

// File: rtl/pkt_trace_rec.sv
module pkt_trace_rec
  import ptr_pkg::*;
#(
  parameter int NPORTS = 6,
  parameter int DEPTH  = 512,
  parameter int MS_W   = 4,
  parameter int DROP_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORTS-1:0]         tap_valid,
  input  logic [NPORTS*PORT_W-1:0]  tap_dst,
  input  logic [NPORTS-1:0]         tap_tail,
  input  logic [NPORTS*TID_W-1:0]   tap_tid,
  input  logic [NPORTS*LEN_W-1:0]   tap_len,
  input  logic [STAT_W-1:0]         q_nonempty,
  input  logic                      rd_start,
  output logic                      rd_valid,
  input  logic                      rd_ready,
  output logic [REC_W-1:0]          rd_data,
  output logic                      rd_last,
  output logic [DROP_W-1:0]         drop_count,
  input  logic [MS_W-1:0]           ms_in,
  input  logic                      ms_clr,
  output logic [MS_W-1:0]           ms_flags
);
  logic              wr_en;
  trace_rec_t        wr_rec;
  trace_rec_t        rd_rec;
  logic [NPORTS-1:0] wr_grant;

  ptr_ingest #(.NPORTS(NPORTS), .DROP_W(DROP_W)) u_ingest (
    .clk        (clk),
    .rst_n      (rst_n),
    .tap_valid  (tap_valid),
    .tap_dst    (tap_dst),
    .tap_tail   (tap_tail),
    .tap_tid    (tap_tid),
    .tap_len    (tap_len),
    .q_stat     (q_nonempty),
    .wr_en      (wr_en),
    .wr_rec     (wr_rec),
    .grant      (wr_grant),
    .drop_count (drop_count)
  );

  ptr_ring #(.DEPTH(DEPTH)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_rec   (wr_rec),
    .rd_start (rd_start),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .rd_rec   (rd_rec),
    .rd_last  (rd_last)
  );

  ptr_milestone #(.MS_W(MS_W)) u_ms (
    .clk      (clk),
    .rst_n    (rst_n),
    .ms_in    (ms_in),
    .ms_clr   (ms_clr),
    .ms_flags (ms_flags)
  );

  assign rd_data = rd_rec;
endmodule

// File: rtl/ptr_chk.sv
module ptr_chk #(
  parameter int MS_W   = 4,
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              rd_last,
  input logic [DROP_W-1:0] drop_count,
  input logic [MS_W-1:0]   ms_in,
  input logic              ms_clr,
  input logic [MS_W-1:0]   ms_flags
);
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid); // R7
  AST_HOLD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> $stable(rd_last)); // R7
  AST_LAST_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid); // R6
  AST_DROP_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_count >= $past(drop_count))); // R4
  AST_MS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_clr |=> ((ms_flags & $past(ms_flags)) == $past(ms_flags))); // R9
  AST_MS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ms_flags & $past(ms_in)) == $past(ms_in))); // R10
endmodule

bind pkt_trace_rec ptr_chk #(.MS_W(MS_W), .DROP_W(DROP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_last    (rd_last),
  .drop_count (drop_count),
  .ms_in      (ms_in),
  .ms_clr     (ms_clr),
  .ms_flags   (ms_flags)
);

// File: tb/pkt_trace_rec_tb.sv
`timescale 1ns/1ps
module pkt_trace_rec_tb;
  localparam int NP    = 6;
  localparam int REC_W = 35;
  localparam int LOGSZ = 512;

  logic clk = 0;
  logic rst_n = 0;
  logic [NP-1:0]    tap_valid = '0;
  logic [NP*3-1:0]  tap_dst = '0;
  logic [NP-1:0]    tap_tail = '0;
  logic [NP*16-1:0] tap_tid = '0;
  logic [NP*8-1:0]  tap_len = '0;
  logic [3:0]       q_nonempty = '0;
  logic             rd_start = 0;
  logic             rd_valid;
  logic             rd_ready = 0;
  logic [REC_W-1:0] rd_data;
  logic             rd_last;
  logic [15:0]      drop_count;
  logic [3:0]       ms_in = '0;
  logic             ms_clr = 0;
  logic [3:0]       ms_flags;

  int nchk = 0;
  int nfail = 0;
  logic [REC_W-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  pkt_trace_rec u_dut (
    .clk(clk), .rst_n(rst_n), .tap_valid(tap_valid), .tap_dst(tap_dst),
    .tap_tail(tap_tail), .tap_tid(tap_tid), .tap_len(tap_len),
    .q_nonempty(q_nonempty), .rd_start(rd_start), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
    .drop_count(drop_count), .ms_in(ms_in), .ms_clr(ms_clr), .ms_flags(ms_flags)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Record model from R2: {tid, size, src, dst, tail, stat}.
  function automatic logic [REC_W-1:0] mkrec(input logic [15:0] id, input logic [7:0] len,
      input int src, input logic [2:0] dst, input logic tail, input logic [3:0] st);
    return {id, len, 3'(src), dst, tail, st};
  endfunction

  task automatic set_tap(input int p, output logic [REC_W-1:0] rec);
    logic [15:0] id;
    logic [7:0]  len;
    logic [2:0]  dst;
    logic        tl;
    id  = 16'($urandom);
    len = 8'($urandom);
    dst = 3'($urandom % 6);
    tl  = 1'($urandom);
    tap_tid[p*16 +: 16] = id;
    tap_len[p*8 +: 8]   = len;
    tap_dst[p*3 +: 3]   = dst;
    tap_tail[p]         = tl;
    rec = mkrec(id, len, p, dst, tl, q_nonempty);
  endtask

  function automatic void push_exp(input logic [REC_W-1:0] r);
    exp_q.push_back(r);
    while (exp_q.size() > LOGSZ) void'(exp_q.pop_front());
  endfunction

  // Burst on the taps in mask; expected order is ascending tap index (R3).
  task automatic fire(input logic [NP-1:0] mask, input int idle);
    logic [REC_W-1:0] r;
    q_nonempty = 4'($urandom);
    for (int p = 0; p < NP; p++) begin
      if (mask[p]) begin
        set_tap(p, r);
        push_exp(r);
      end
    end
    tap_valid = mask;
    @(negedge clk);
    tap_valid = '0;
    repeat (idle) @(negedge clk);
  endtask

  task automatic do_read(input int inject_at, input int restart_at, input string tag);
    logic [REC_W-1:0] snap[$];
    logic [REC_W-1:0] held, fa, fe, r;
    int got = 0, bad = 0, lastbad = 0, holdbad = 0, guard = 0;
    bit done = 0, stall = 0, injected = 0, restarted = 0;
    snap = exp_q;
    rd_start = 1;
    @(negedge clk);
    rd_start = 0;
    if (snap.size() == 0) begin
      for (int i = 0; i < 4; i++) begin
        if (rd_valid) bad++;
        @(negedge clk);
      end
      check(bad == 0, {"R6 empty log gives no beats ", tag}, bad, 0);
      return;
    end
    while (!done && guard < 20000) begin
      guard++;
      if (stall && (!rd_valid || rd_data !== held)) holdbad++;
      tap_valid = '0;
      rd_start  = 0;
      if (got == inject_at && !injected) begin
        injected = 1;
        set_tap(4, r);
        push_exp(r);
        tap_valid = 6'b010000;
      end
      if (got == restart_at && !restarted) begin
        restarted = 1;
        rd_start  = 1;
      end
      rd_ready = ($urandom % 4) != 0;
      stall = 0;
      if (rd_valid) begin
        if (rd_ready) begin
          if (got < snap.size() && rd_data !== snap[got]) begin
            if (bad == 0) begin fa = rd_data; fe = snap[got]; end
            bad++;
          end
          if (rd_last !== (got == snap.size() - 1)) lastbad++;
          got++;
          if (rd_last) done = 1;
        end else begin
          stall = 1;
          held  = rd_data;
        end
      end
      @(negedge clk);
    end
    rd_ready  = 0;
    rd_start  = 0;
    tap_valid = '0;
    check(got == snap.size(), {"R6 beat count ", tag}, got, snap.size());
    check(bad == 0, {"R2 R3 record contents oldest first ", tag}, fa, fe);
    check(lastbad == 0, {"R6 rd_last on newest only ", tag}, lastbad, 0);
    check(holdbad == 0, {"R7 hold under back-pressure ", tag}, holdbad, 0);
    repeat (3) @(negedge clk);
    check(rd_valid == 0, {"R7 stray start ignored, stream idle ", tag}, rd_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [REC_W-1:0] ra [NP];
    logic [REC_W-1:0] r0b, rx;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(rd_valid == 0 && rd_last == 0, "R1 readout idle after reset", {rd_valid, rd_last}, 0);
    check(drop_count == 0, "R1 drop count zero", drop_count, 0);
    check(ms_flags == 0, "R1 milestone flags zero", ms_flags, 0);
    do_read(-1, -1, "(empty)");

    // R2 R3 random bursts
    for (int b = 0; b < 40; b++) fire(6'(($urandom % 63) + 1), NP + 1);
    do_read(-1, -1, "(random bursts)");

    // R3 R4 directed: drained tap refills, waiting tap is dropped
    q_nonempty = 4'h9;
    for (int p = 0; p < NP; p++) set_tap(p, ra[p]);
    tap_valid = '1;
    @(negedge clk);
    q_nonempty = 4'h6;
    set_tap(0, r0b);
    set_tap(5, rx);
    tap_valid = 6'b100001;
    @(negedge clk);
    tap_valid = '0;
    push_exp(ra[0]);
    push_exp(r0b);
    for (int p = 1; p < NP; p++) push_exp(ra[p]);
    repeat (10) @(negedge clk);
    check(drop_count == 1, "R4 one discarded event counted", drop_count, 1);
    do_read(-1, -1, "(refill and drop)");

    // R8 capture during readout, R7 stray start mid-stream
    do_read(3, 2, "(capture during read)");
    repeat (4) @(negedge clk);
    do_read(-1, -1, "(R8 new record visible)");

    // R5 wraparound
    for (int i = 0; i < 600; i++) fire(6'(1 << ($urandom % NP)), 0);
    repeat (4) @(negedge clk);
    check(exp_q.size() == LOGSZ, "R5 model holds 512", exp_q.size(), LOGSZ);
    do_read(-1, -1, "(R5 wrapped log)");
    check(drop_count == 1, "R4 no drops from single events", drop_count, 1);

    // R9 milestones sticky
    ms_in = 4'b0001; @(negedge clk); ms_in = 0; @(negedge clk);
    check(ms_flags == 4'b0001, "R9 flag stays set after pulse", ms_flags, 4'b0001);
    ms_in = 4'b0100; @(negedge clk); ms_in = 0; repeat (3) @(negedge clk);
    check(ms_flags == 4'b0101, "R9 flags accumulate", ms_flags, 4'b0101);
    // R10 clear
    ms_clr = 1; @(negedge clk); ms_clr = 0; @(negedge clk);
    check(ms_flags == 4'b0000, "R10 clear empties flags", ms_flags, 0);
    ms_in = 4'b0010; ms_clr = 1; @(negedge clk); ms_clr = 0; ms_in = 0; @(negedge clk);
    check(ms_flags == 4'b0010, "R10 clear reloads live input", ms_flags, 4'b0010);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule